// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block turns an asynchronous serial line into bytes that a processor can read. It watches the line at a multiple of the bit rate: 1, 16 or 64 samples per bit. It finds the falling edge that starts a frame and checks that the start bit is still low at its centre. It then samples each data bit, the optional parity bit and the first stop bit at their centres. The finished character goes into a receive data register. The checks made on it go into a status register as flags.

The processor reads through a two-location port. One location returns the status byte and the other returns the received character. Each flag has its own clear rule, and some of those rules depend on the order of reads. One enable bit turns all of the receiver's interrupt causes into a request. That request is combined with an interrupt request coming in from the transmitter to form one output line. The word-format and divide settings come in as plain configuration inputs, shared with the transmitter.

Top module: `sr_receiver`

## Requirements
- R1: A read with `rd_sel`=0 returns the status byte. Its fields are: bit0 = receive register full, bit2 = carrier lost, bit4 = framing error, bit5 = overrun, bit6 = parity error, bit7 = interrupt request. Bits 1 and 3 read 0. A read with `rd_sel`=1 returns the received character. All flags are 0 after reset.
- R2: A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop bit. `cfg_len8`=1 selects 8 data bits. `cfg_len8`=0 selects 7 data bits, and the character then reads back with bit7 = 0.
- R3: `cfg_div` 2'b01 samples 16 times per bit and takes each bit at its 8th sample. 2'b10 samples 64 times per bit and takes each bit at its 32nd sample. 2'b00 takes one sample per bit on every clock. In the 16 and 64 modes, a low pulse that is high again at the start bit's centre is dropped and produces no character.
- R4: The full flag is set when a character is stored. It is cleared by a data read or by `mrst`.
- R5: A character that completes while the full flag is set, with no data read in that cycle, sets the overrun flag. That character is discarded and the stored character is kept. Overrun is cleared by a data read or by `mrst`.
- R6: `cfg_par` 2'b01 selects even parity and 2'b10 selects odd parity. A mismatch between the received parity bit and the parity of the data sets the parity-error flag. The parity-error and framing-error flags are replaced only when the next character is stored, or cleared by `mrst`. They keep their value across reads.
- R7: With `cfg_par` 2'b00 no parity bit is expected, and every stored character leaves the parity-error flag at 0.
- R8: The framing-error flag is set when the first stop bit is sampled low.
- R9: A rising edge on `carrier_lost` sets the carrier flag. The flag clears only when a status read made while it is set is followed by a data read. A data read on its own leaves it set.
- R10: `irq` (status bit7) is high when `tx_irq` is high, or when `cfg_rie` is high and any of full, overrun or carrier is set.
- R11: `mrst` clears every flag and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial data in, high when idle |
| cfg_div | input | 2 | Samples per bit: 00 one, 01 sixteen, 10 sixty-four |
| cfg_len8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| cfg_par | input | 2 | 00 none, 01 even, 10 odd |
| cfg_rie | input | 1 | Receiver interrupt enable |
| mrst | input | 1 | Master reset of the receiver and its flags |
| carrier_lost | input | 1 | High while the carrier is absent |
| tx_irq | input | 1 | Interrupt request from the transmitter |
| rd_en | input | 1 | Read strobe, one clock per access |
| rd_sel | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| irq | output | 1 | Composite interrupt request |

## Verification
The properties assume that each read strobe lasts a single clock, that `mrst` is a pulse, and that the format and divide inputs do not change while a frame is arriving. The bench changes configuration only while the line is idle and after earlier frames have completed. It holds every serial bit for exactly the number of clocks its divide setting calls for. It raises each read strobe for one clock, with idle clocks between accesses.

// File: rtl/sr_pkg.sv
package sr_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    DIV_X1  = 2'b00,
    DIV_X16 = 2'b01,
    DIV_X64 = 2'b10
  } div_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10
  } par_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // Parity bit a sender would attach to this character.
  function automatic logic parity_bit(input logic [CHAR_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Status byte layout seen by the processor.
  function automatic logic [CHAR_W-1:0] pack_status(
    input logic full, input logic carrier, input logic ferr,
    input logic ovrn, input logic perr, input logic req);
    return {req, perr, ovrn, ferr, 1'b0, carrier, 1'b0, full};
  endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sr_framer.sv
module sr_framer
  import sr_pkg::*;
#(
  parameter int OVS_MID = 16,
  parameter int OVS_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rx_s,
  input  logic [1:0]        cfg_div,
  input  logic              cfg_len8,
  input  logic [1:0]        cfg_par,
  output logic              done,
  output logic [CHAR_W-1:0] char_out,
  output logic              par_bad,
  output logic              stop_bad,
  output logic              centre
);
  localparam int CW = $clog2(OVS_HI);
  localparam int IW = $clog2(CHAR_W + 1);

  rx_state_e         st;
  logic [CW-1:0]     wait_q;
  logic [IW-1:0]     idx;
  logic [CHAR_W-1:0] shr;
  logic              par_q;
  logic              rx_q;

  div_e              dsel;
  par_e              psel;
  logic [CW-1:0]     ovs_m1, half_m1;
  logic [IW-1:0]     last_idx;
  logic              single;
  logic [CHAR_W-1:0] assembled;
  logic              expect_par;

  assign dsel = div_e'(cfg_div);
  assign psel = par_e'(cfg_par);

  always_comb begin
    ovs_m1  = '0;
    half_m1 = '0;
    single  = 1'b1;
    case (dsel)
      DIV_X16: begin ovs_m1 = CW'(OVS_MID - 1); half_m1 = CW'(OVS_MID/2 - 1); single = 1'b0; end
      DIV_X64: begin ovs_m1 = CW'(OVS_HI - 1);  half_m1 = CW'(OVS_HI/2 - 1);  single = 1'b0; end
      default: ;
    endcase
  end

  assign last_idx   = cfg_len8 ? IW'(CHAR_W - 1) : IW'(CHAR_W - 2);
  assign assembled  = cfg_len8 ? shr : (shr >> 1);
  assign expect_par = parity_bit(assembled, psel == PAR_ODD);
  assign centre     = (st != RX_IDLE) && (wait_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; wait_q <= '0; idx <= '0; shr <= '0; par_q <= 1'b0; rx_q <= 1'b1;
      done <= 1'b0; char_out <= '0; par_bad <= 1'b0; stop_bad <= 1'b0;
    end else if (clr) begin
      st <= RX_IDLE; wait_q <= '0; idx <= '0; shr <= '0; par_q <= 1'b0; rx_q <= rx_s;
      done <= 1'b0;
    end else begin
      rx_q <= rx_s;
      done <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (rx_q && !rx_s) begin
            idx <= '0;
            if (single) begin st <= RX_DATA;  wait_q <= '0; end
            else        begin st <= RX_START; wait_q <= half_m1; end
          end
        end
        RX_START: begin
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else if (rx_s) st <= RX_IDLE;
          else begin st <= RX_DATA; wait_q <= ovs_m1; end
        end
        RX_DATA: begin
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else begin
            shr    <= {rx_s, shr[CHAR_W-1:1]};
            wait_q <= ovs_m1;
            idx    <= idx + 1'b1;
            if (idx == last_idx) st <= (psel == PAR_NONE) ? RX_STOP : RX_PAR;
          end
        end
        RX_PAR: begin
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else begin par_q <= rx_s; wait_q <= ovs_m1; st <= RX_STOP; end
        end
        RX_STOP: begin
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else begin
            done     <= 1'b1;
            char_out <= assembled;
            stop_bad <= !rx_s;
            par_bad  <= (psel != PAR_NONE) && (par_q != expect_par);
            st       <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sr_status.sv
module sr_status
  import sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              done,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              par_bad,
  input  logic              stop_bad,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              carrier_lost,
  input  logic              tx_irq,
  input  logic              cfg_rie,
  output logic [CHAR_W-1:0] rd_data,
  output logic              irq,
  output logic              data_rd,
  output logic              stat_rd,
  output logic              full,
  output logic              ovrn,
  output logic              perr,
  output logic              ferr,
  output logic              carrier
);
  logic [CHAR_W-1:0] rdr;
  logic              armed, cl_q;
  logic              load_evt, ovr_evt, carrier_set;

  assign data_rd     = rd_en && rd_sel;
  assign stat_rd     = rd_en && !rd_sel;
  assign load_evt    = done && (!full || data_rd);
  assign ovr_evt     = done && full && !data_rd;
  assign carrier_set = carrier_lost && !cl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr <= '0; full <= 1'b0; ovrn <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
      carrier <= 1'b0; armed <= 1'b0; cl_q <= 1'b0;
    end else if (clr) begin
      rdr <= '0; full <= 1'b0; ovrn <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
      carrier <= 1'b0; armed <= 1'b0; cl_q <= carrier_lost;
    end else begin
      cl_q <= carrier_lost;
      if (load_evt) begin
        rdr  <= char_in;
        perr <= par_bad;
        ferr <= stop_bad;
        full <= 1'b1;
      end else if (data_rd) begin
        full <= 1'b0;
      end
      if (ovr_evt)      ovrn <= 1'b1;
      else if (data_rd) ovrn <= 1'b0;
      if (carrier_set)           carrier <= 1'b1;
      else if (data_rd && armed) carrier <= 1'b0;
      if (stat_rd && carrier) armed <= 1'b1;
      else if (data_rd)       armed <= 1'b0;
    end
  end

  assign irq     = tx_irq || (cfg_rie && (full || ovrn || carrier));
  assign rd_data = rd_sel ? rdr : pack_status(full, carrier, ferr, ovrn, perr, irq);
endmodule

// File: rtl/sr_receiver.sv
module sr_receiver
  import sr_pkg::*;
#(
  parameter int OVS_MID     = 16,
  parameter int OVS_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic [1:0] cfg_div,
  input  logic       cfg_len8,
  input  logic [1:0] cfg_par,
  input  logic       cfg_rie,
  input  logic       mrst,
  input  logic       carrier_lost,
  input  logic       tx_irq,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic              rx_s;
  logic              ch_done, ch_pbad, ch_fbad, bit_centre;
  logic [CHAR_W-1:0] ch_data;
  logic              data_rd, stat_rd;
  logic              st_full, st_ovrn, st_pe, st_fe, st_dcd;

  sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s));

  sr_framer #(.OVS_MID(OVS_MID), .OVS_HI(OVS_HI)) u_framer (
    .clk(clk), .rst_n(rst_n), .clr(mrst), .rx_s(rx_s),
    .cfg_div(cfg_div), .cfg_len8(cfg_len8), .cfg_par(cfg_par),
    .done(ch_done), .char_out(ch_data), .par_bad(ch_pbad),
    .stop_bad(ch_fbad), .centre(bit_centre));

  sr_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(mrst), .done(ch_done), .char_in(ch_data),
    .par_bad(ch_pbad), .stop_bad(ch_fbad), .rd_en(rd_en), .rd_sel(rd_sel),
    .carrier_lost(carrier_lost), .tx_irq(tx_irq), .cfg_rie(cfg_rie),
    .rd_data(rd_data), .irq(irq), .data_rd(data_rd), .stat_rd(stat_rd),
    .full(st_full), .ovrn(st_ovrn), .perr(st_pe), .ferr(st_fe), .carrier(st_dcd));
endmodule

// File: rtl/sr_receiver_chk.sv
module sr_receiver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mrst,
  input logic [1:0] cfg_par,
  input logic       cfg_rie,
  input logic       tx_irq,
  input logic       irq,
  input logic       ch_done,
  input logic       data_rd,
  input logic       st_full,
  input logic       st_ovrn,
  input logic       st_pe,
  input logic       st_fe,
  input logic       st_dcd
);
  a_r4_full_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done && !mrst |=> st_full);

  a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !ch_done && !mrst |=> !st_full);

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done && st_full && !data_rd && !mrst |=> st_ovrn);

  a_r5_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !mrst |=> !st_ovrn);

  a_r6_error_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_done && !mrst |=> $stable(st_pe) && $stable(st_fe));

  a_r7_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done && cfg_par == 2'b00 && (!st_full || data_rd) && !mrst |=> !st_pe);

  a_r9_carrier_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_dcd) |-> $past(data_rd) || $past(mrst));

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq && !cfg_rie |-> !irq);

  a_r10_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rie && st_full |-> irq);

  a_r11_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> !st_full && !st_ovrn && !st_pe && !st_fe && !st_dcd);
endmodule

bind sr_receiver sr_receiver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mrst(mrst), .cfg_par(cfg_par), .cfg_rie(cfg_rie),
  .tx_irq(tx_irq), .irq(irq), .ch_done(ch_done), .data_rd(data_rd),
  .st_full(st_full), .st_ovrn(st_ovrn), .st_pe(st_pe), .st_fe(st_fe),
  .st_dcd(st_dcd));

// File: tb/tb_sr_receiver.sv
module tb_sr_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_div = 2'b01;
  logic       cfg_len8 = 1'b1;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_rie = 1'b1;
  logic       mrst = 1'b0;
  logic       carrier_lost = 1'b0;
  logic       tx_irq = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;
  logic [7:0] v;

  always #10 clk = ~clk;

  sr_receiver dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_div(cfg_div),
    .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_rie(cfg_rie), .mrst(mrst),
    .carrier_lost(carrier_lost), .tx_irq(tx_irq), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic sel);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #2 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic put_bit(input logic b, input int ovs);
    @(negedge clk);
    rx_line = b;
    repeat (ovs - 1) @(negedge clk);
  endtask

  function automatic int ovs_of(input logic [1:0] d);
    return (d == 2'b01) ? 16 : (d == 2'b10) ? 64 : 1;
  endfunction

  task automatic send(input logic [7:0] data, input logic badpar, input logic badstop);
    int ovs = ovs_of(cfg_div);
    int nb = cfg_len8 ? 8 : 7;
    int ones = 0;
    logic pb;
    put_bit(1'b0, ovs);
    for (int i = 0; i < nb; i++) begin
      put_bit(data[i], ovs);
      ones += int'(data[i]);
    end
    if (cfg_par != 2'b00) begin
      pb = ones[0] ^ (cfg_par == 2'b10);
      put_bit(pb ^ badpar, ovs);
    end
    put_bit(!badstop, ovs);
    @(negedge clk);
    rx_line = 1'b1;
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    rd(1'b0); check("R1 reset status", v, 8'h00);
    check("R10 reset irq", {7'd0, irq}, 8'h00);

    // Sweep over divide, length and parity settings
    for (int d = 0; d < 3; d++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 3; p++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] dat;
            logic bp;
            cfg_div = 2'(d); cfg_len8 = l[0]; cfg_par = 2'(p); cfg_rie = 1'b1;
            dat = 8'(k * 91 + d * 17 + p * 5 + l);
            bp = (k == 3) && (p != 0);
            send(dat, bp, 1'b0);
            rd(1'b0);
            check("R3 R4 R6 R7 status after frame", v, bp ? 8'hC1 : 8'h81);
            rd(1'b1);
            check("R2 received char", v, l[0] ? dat : (dat & 8'h7F));
            rd(1'b0);
            check("R4 R6 status after data read", v, bp ? 8'h40 : 8'h00);
          end

    cfg_div = 2'b01; cfg_len8 = 1'b1; cfg_par = 2'b01; cfg_rie = 1'b1;

    // R3 false start
    @(negedge clk); rx_line = 1'b0;
    idle(4); rx_line = 1'b1;
    idle(40);
    rd(1'b0); check("R3 false start ignored", v, 8'h40);

    // R8 framing error
    send(8'h3C, 1'b0, 1'b1);
    rd(1'b0); check("R8 framing error", v, 8'h91);
    rd(1'b1); check("R8 char with bad stop", v, 8'h3C);
    send(8'h96, 1'b0, 1'b0);
    rd(1'b0); check("R6 flags replaced by next char", v, 8'h81);
    rd(1'b1);

    // R5 overrun
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    rd(1'b0); check("R5 overrun status", v, 8'hA1);
    rd(1'b1); check("R5 first char kept", v, 8'h11);
    rd(1'b0); check("R5 overrun cleared by data read", v, 8'h00);

    // R9 carrier loss clear order
    carrier_lost = 1'b1;
    idle(3);
    rd(1'b1);
    rd(1'b0); check("R9 data read alone leaves carrier", v, 8'h84);
    rd(1'b1);
    rd(1'b0); check("R9 status then data read clears", v, 8'h00);
    carrier_lost = 1'b0;
    idle(2);

    // R10 interrupt composition
    cfg_rie = 1'b0;
    send(8'h5A, 1'b0, 1'b0);
    check("R10 irq masked", {7'd0, irq}, 8'h00);
    rd(1'b0); check("R10 status without request", v, 8'h01);
    tx_irq = 1'b1;
    idle(1);
    check("R10 irq from transmitter", {7'd0, irq}, 8'h01);
    tx_irq = 1'b0;

    // R11 master reset
    cfg_rie = 1'b1;
    @(negedge clk); mrst = 1'b1;
    @(negedge clk); mrst = 1'b0;
    rd(1'b0); check("R11 master reset clears flags", v, 8'h00);
    // R11 abort mid-frame: start a frame, reset, then a clean frame
    @(negedge clk); rx_line = 1'b0;
    idle(20);
    mrst = 1'b1;
    @(negedge clk); mrst = 1'b0; rx_line = 1'b1;
    idle(200);
    rd(1'b0); check("R11 aborted frame gives no char", v, 8'h00);
    send(8'hE7, 1'b0, 1'b0);
    rd(1'b1); check("R11 receiver usable after reset", v, 8'hE7);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule